// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter units behind a small register port. Each unit has a low count byte and a high count byte. A unit advances on a machine-cycle `tick` or on falling edges of its own external count pin. A run bit enables it. A gate option can also make counting depend on a level-sensitive enable pin, which allows a pulse width to be measured in ticks.

A shared mode register selects one of four counting shapes for each unit:

| Mode value | Shape |
|---|---|
| 0 | 13-bit prescaled counter |
| 1 | Full 16-bit counter |
| 2 | 8-bit counter with auto-reload |
| 3 | Split mode |

When the first unit is in split mode, its two bytes run as separate 8-bit counters. When the second unit is given mode 3, it simply halts.

Each unit has a sticky overflow flag. Software can write the flag, and an acknowledge pulse clears it.

Software reaches all state through the register port. Writes take effect at the next clock edge. `rd_data` is a combinational view of the addressed register. There is no back-pressure: every write is accepted in the cycle it is presented.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every readable register reads 0 and `ovf` is 0.
- R2: The register map is as follows.
  - Address 0 is unit 0 low byte, 1 is unit 0 high byte, 2 is unit 1 low byte and 3 is unit 1 high byte.
  - Address 4 is the mode register. Per unit u it holds mode in bits [4u+1:4u], source select in bit 4u+2 (1 = external pin edges) and gate in bit 4u+3.
  - Address 5 is the control register: run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3. Its upper bits read 0.
  - Every written field reads back.
- R3: A unit advances only while its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is high. The pin is seen after a two-flop synchroniser.
- R4: With the source select bit at 1, a unit advances once per falling edge of its `cnt_pin` bit. The edge is detected after synchronisation, so it counts within three cycles. Ticks are then not counted.
- R5: Mode 0 counts the 13-bit value {high byte, low byte[4:0]}. Low byte bits [7:5] keep their value. Wrapping from 0x1FFF to 0 sets the unit's flag.
- R6: Mode 1 counts the 16-bit value {high, low}. Wrapping from 0xFFFF to 0 sets the unit's flag.
- R7: In mode 2 the low byte counts. When it passes 0xFF it is loaded from the high byte and the flag is set. The high byte never changes by counting.
- R8: While unit 1 is in mode 3, neither of its count bytes changes except by register write.
- R9: While unit 0 is in mode 3, the following hold:
  - Unit 0's low byte counts as an 8-bit counter under unit 0's own run, gate and source settings, and sets flag0 on wrap.
  - Unit 0's high byte counts ticks while run1 is 1, and its wrap sets flag1.
  - Unit 1 keeps counting in its own mode, but its wraps no longer set flag1.
- R10: A flag is set by hardware wrap and by writing 1 to it. It is cleared by writing 0 to it or by a one-cycle `irq_ack` pulse. A hardware set in the same cycle wins. `ovf` mirrors the flags.
- R11: Setting the run bit leaves the count registers unchanged. Counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle count enable for internal timing |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate-enable pins, one per unit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data of the addressed register |
| irq_ack | input | 2 | Flag-clear pulses, one per unit |
| ovf | output | 2 | Overflow flags |

## Verification
The checker assumes that a register write and counting never target the same count byte in a hold check. For that reason, each hold property is qualified with no write in the cycle. The bench keeps to this by changing modes and preloading counts only while run bits are 0.

The acknowledge property assumes that no wrap and no control write coincide with the pulse. The bench issues `irq_ack` only after stopping both units.

External pins are driven with levels held for several cycles, so the synchroniser never sees a pulse shorter than one clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] ADR_MODE = 3'd4;
  localparam logic [2:0] ADR_CTRL = 3'd5;
  localparam int UNITS = 2;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign fall = prev & ~sh[STAGES-1];
endmodule

// File: rtl/tmr_step.sv
module tmr_step import tmr_pkg::*; #(
  parameter int W   = 8,
  parameter int PRE = 5
) (
  input  tmr_mode_e      mode,
  input  logic           inc,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   hi,
  output logic [W-1:0]   lo_n,
  output logic [W-1:0]   hi_n,
  output logic           wrap
);
  localparam int PW = W + PRE;
  localparam int FW = 2 * W;
  localparam logic [PW-1:0] ONE_P = PW'(1);
  localparam logic [FW-1:0] ONE_F = FW'(1);
  localparam logic [W-1:0]  ONE_B = W'(1);

  logic [PW-1:0] p_sum;
  logic [FW-1:0] f_sum;
  logic [W-1:0]  b_sum;

  assign p_sum = {hi, lo[PRE-1:0]} + ONE_P;
  assign f_sum = {hi, lo} + ONE_F;
  assign b_sum = lo + ONE_B;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    if (inc) begin
      unique case (mode)
        MD_PRE13: begin
          hi_n          = p_sum[PW-1:PRE];
          lo_n[PRE-1:0] = p_sum[PRE-1:0];
          wrap          = &{hi, lo[PRE-1:0]};
        end
        MD_FULL16: begin
          {hi_n, lo_n} = f_sum;
          wrap         = &{hi, lo};
        end
        MD_RELOAD8: begin
          wrap = &lo;
          lo_n = (&lo) ? hi : b_sum;
        end
        default: begin
          lo_n = b_sum;
          wrap = &lo;
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int W    = 8,
  parameter int PRE  = 5,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   cnt_pin,
  input  logic [1:0]   gate_pin,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   irq_ack,
  output logic [1:0]   ovf
);
  localparam logic [W-1:0] ONE_B = W'(1);

  logic [UNITS-1:0][W-1:0] lo_q, hi_q, lo_nx, hi_nx;
  logic [7:0]              mode_q;
  logic [UNITS-1:0]        run_q, ovf_q, ovf_set;
  logic [UNITS-1:0]        gate_lvl, cnt_fall, en, step_inc, wrap;
  tmr_mode_e               md [UNITS];
  logic                    split, hs_inc, hs_wrap, ctrl_wr;
  logic [W-1:0]            hi0_next;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic cnt_lvl_unused;
    logic gate_fall_unused;

    assign md[u] = tmr_mode_e'(mode_q[4*u+1 -: 2]);

    tmr_pin_sync #(.STAGES(SYNC)) u_cnt (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[u]),
      .lvl(cnt_lvl_unused), .fall(cnt_fall[u])
    );
    tmr_pin_sync #(.STAGES(SYNC)) u_gate (
      .clk(clk), .rst_n(rst_n), .pin(gate_pin[u]),
      .lvl(gate_lvl[u]), .fall(gate_fall_unused)
    );

    assign en[u] = run_q[u] & (~mode_q[4*u+3] | gate_lvl[u])
                 & (mode_q[4*u+2] ? cnt_fall[u] : tick);

    tmr_step #(.W(W), .PRE(PRE)) u_step (
      .mode(md[u]), .inc(step_inc[u]), .lo(lo_q[u]), .hi(hi_q[u]),
      .lo_n(lo_nx[u]), .hi_n(hi_nx[u]), .wrap(wrap[u])
    );
  end

  // unit 1 in mode 3 is frozen; unit 0 in mode 3 lends its high byte to run1
  assign step_inc[0] = en[0];
  assign step_inc[1] = en[1] & (md[1] != MD_SPLIT);
  assign split       = (md[0] == MD_SPLIT);
  assign hs_inc      = split & run_q[1] & tick;
  assign hs_wrap     = hs_inc & (&hi_q[0]);
  assign hi0_next    = split ? (hs_inc ? hi_q[0] + ONE_B : hi_q[0]) : hi_nx[0];
  assign ovf_set[0]  = wrap[0];
  assign ovf_set[1]  = split ? hs_wrap : wrap[1];
  assign ctrl_wr     = wr_en & (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
    end else begin
      for (int u = 0; u < UNITS; u++) begin
        if (wr_en && addr == 3'(2*u))
          lo_q[u] <= wr_data;
        else
          lo_q[u] <= lo_nx[u];
        if (wr_en && addr == 3'(2*u+1))
          hi_q[u] <= wr_data;
        else
          hi_q[u] <= (u == 0) ? hi0_next : hi_nx[u];
        ovf_q[u] <= ovf_set[u] | ((ctrl_wr ? wr_data[2+u] : ovf_q[u]) & ~irq_ack[u]);
      end
      if (wr_en && addr == ADR_MODE) mode_q <= wr_data[7:0];
      if (ctrl_wr)                   run_q  <= wr_data[1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      3'd0:     rd_data = lo_q[0];
      3'd1:     rd_data = hi_q[0];
      3'd2:     rd_data = lo_q[1];
      3'd3:     rd_data = hi_q[1];
      ADR_MODE: rd_data[7:0] = mode_q;
      ADR_CTRL: rd_data[3:0] = {ovf_q, run_q};
      default:  rd_data = '0;
    endcase
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [1:0]   irq_ack,
  input logic [1:0]   ovf,
  input logic [1:0]   ovf_set,
  input logic [7:0]   mode_q,
  input logic [1:0]   run_q,
  input logic [W-1:0] lo0,
  input logic [W-1:0] hi0,
  input logic [W-1:0] lo1,
  input logic [W-1:0] hi1
);
  AST_RUN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !wr_en) |=> lo0 == $past(lo0)); // R3

  AST_PRE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0 && !wr_en) |=> lo0[7:5] == $past(lo0[7:5])); // R5

  AST_RELOAD_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd2 && !wr_en) |=> hi0 == $past(hi0)); // R7

  AST_UNIT1_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'd3 && !wr_en) |=> (lo1 == $past(lo1) && hi1 == $past(hi1))); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !ovf_set[0] && !(wr_en && addr == 3'd5)) |=> !ovf[0]); // R10
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .irq_ack(irq_ack), .ovf(ovf), .ovf_set(ovf_set),
  .mode_q(mode_q), .run_q(run_q),
  .lo0(lo_q[0]), .hi0(hi_q[0]), .lo1(lo_q[1]), .hi1(hi_q[1])
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] cnt_pin = '0, gate_pin = '0, irq_ack = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_pair u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_ack(irq_ack), .ovf(ovf));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] run);
    logic [7:0] c;
    rd(3'd5, c);
    wr(3'd5, {4'b0, c[3:2], run});
  endtask

  task automatic run_for(input logic [1:0] run, input int n);
    wr_ctrl(run);
    repeat (n - 1) @(negedge clk);
    wr_ctrl(2'b00);
  endtask

  task automatic ack(input logic [1:0] m);
    irq_ack = m; @(negedge clk); irq_ack = '0;
  endtask

  task automatic chk_cnt(string tag, int u, logic [7:0] lo, logic [7:0] hi);
    logic [7:0] v;
    rd(3'(2*u), v);   chk({tag, " low"}, v, lo);
    rd(3'(2*u+1), v); chk({tag, " high"}, v, hi);
  endtask

  task automatic preload(logic [7:0] mode, logic [7:0] l0, logic [7:0] h0);
    wr(3'd4, mode); wr(3'd0, l0); wr(3'd1, h0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset ovf", {6'b0, ovf}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78);
    wr(3'd4, 8'hA5);
    rd(3'd0, v); chk("R2 lo0", v, 8'h12);
    rd(3'd1, v); chk("R2 hi0", v, 8'h34);
    rd(3'd2, v); chk("R2 lo1", v, 8'h56);
    rd(3'd3, v); chk("R2 hi1", v, 8'h78);
    rd(3'd4, v); chk("R2 mode", v, 8'hA5);
    wr(3'd5, 8'hFC);
    rd(3'd5, v); chk("R2 ctrl flags", v, 8'h0C);
    chk("R10 sw set", {6'b0, ovf}, 8'h03);
    wr(3'd5, 8'h00);
    chk("R10 sw clear", {6'b0, ovf}, 8'h00);
  endtask

  task automatic t_mode1();
    preload(8'h01, 8'hFE, 8'hFF);
    run_for(2'b01, 3);
    chk_cnt("R6 wrap16", 0, 8'h01, 8'h00);
    chk("R6 flag", {6'b0, ovf}, 8'h01);
    ack(2'b01);
    chk("R10 ack clear", {6'b0, ovf}, 8'h00);
  endtask

  task automatic t_mode0();
    preload(8'h00, 8'hFE, 8'hFF);
    run_for(2'b01, 3);
    chk_cnt("R5 wrap13", 0, 8'hE1, 8'h00);
    chk("R5 flag", {6'b0, ovf}, 8'h01);
    ack(2'b01);
    preload(8'h00, 8'h5F, 8'h02);
    run_for(2'b01, 2);
    chk_cnt("R5 carry into high", 0, 8'h41, 8'h03);
    chk("R5 no flag", {6'b0, ovf}, 8'h00);
  endtask

  task automatic t_mode2();
    preload(8'h02, 8'hFD, 8'hF0);
    run_for(2'b01, 5);
    chk_cnt("R7 reload", 0, 8'hF2, 8'hF0);
    chk("R7 flag", {6'b0, ovf}, 8'h01);
    ack(2'b01);
  endtask

  task automatic t_gate();
    preload(8'h09, 8'h00, 8'h00);
    gate_pin[0] = 1'b0;
    run_for(2'b01, 10);
    chk_cnt("R3 gate pin low", 0, 8'h00, 8'h00);
    gate_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    run_for(2'b01, 10);
    chk_cnt("R3 gate pin high", 0, 8'h0A, 8'h00);
    run_for(2'b01, 4);
    chk_cnt("R11 resume from held", 0, 8'h0E, 8'h00);
    gate_pin[0] = 1'b0;
  endtask

  task automatic t_ext();
    preload(8'h05, 8'h00, 8'h00);
    wr_ctrl(2'b01);
    for (int i = 0; i < 3; i++) begin
      cnt_pin[0] = 1'b1; repeat (3) @(negedge clk);
      cnt_pin[0] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr_ctrl(2'b00);
    chk_cnt("R4 edges counted", 0, 8'h03, 8'h00);
  endtask

  task automatic t_unit1();
    wr(3'd4, 8'h30); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    run_for(2'b10, 5);
    chk_cnt("R8 unit1 halted", 1, 8'h10, 8'h00);
    wr(3'd4, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_for(2'b10, 1);
    chk_cnt("R6 unit1 wrap", 1, 8'h00, 8'h00);
    chk("R6 unit1 flag", {6'b0, ovf}, 8'h02);
    ack(2'b10);
  endtask

  task automatic t_split();
    preload(8'h13, 8'hFE, 8'hFD);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_for(2'b01, 3);
    chk_cnt("R9 split low", 0, 8'h01, 8'hFD);
    chk("R9 low flag0", {6'b0, ovf}, 8'h01);
    ack(2'b01);
    run_for(2'b10, 4);
    chk_cnt("R9 split high", 0, 8'h01, 8'h01);
    chk("R9 high sets flag1", {6'b0, ovf}, 8'h02);
    chk_cnt("R9 unit1 still counts", 1, 8'h04, 8'h00);
    ack(2'b10);
    wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_for(2'b10, 2);
    chk_cnt("R9 high byte", 0, 8'h01, 8'h02);
    chk_cnt("R9 unit1 wrapped", 1, 8'h01, 8'h00);
    chk("R9 unit1 wrap no flag", {6'b0, ovf}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mode1();
    t_mode0();
    t_mode2();
    t_gate();
    t_ext();
    t_unit1();
    t_split();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule